// File: doc/BRIEF.md
# Audio Master Clock Divider

This block derives the serial bit clock (SCLK) and the frame clock (LRCK) of an audio converter operating as clock master, using nothing but the master clock. The master clock first passes through a prescaler chain. The first stage divides by 3/2 or by 1, and two independent stages follow, each of which halves the rate or passes it through. A two-bit speed code then sets how many prescaled ticks make up one SCLK period and one frame. Every speed keeps 64 SCLK periods per frame.

All outputs sit in the master-clock domain. SCLK and LRCK are registered levels. Three single-cycle enables mark the first cycle after each SCLK rise, each SCLK fall and each LRCK change, so that downstream logic can run off the master clock. The prescaler is built as an enable pattern rather than a derived clock.

The select inputs are sampled only at frame boundaries, which are the LRCK falling edges, and while reset is held. A change to any select therefore never produces a short or stretched frame.

Top module: `audio_mclk_div`

## Requirements
- R1: While the synchronous reset `rst` is high, `sclk_o`, `lrck_o`, `sclk_rise_o`, `sclk_fall_o` and `lrck_edge_o` are all 0 from the first clock edge on.
- R2: After reset is released, `lrck_o` reads 1 for the first time right after the H-th rising clock edge with `rst` low, where H = F*A*B*T/2. In this formula T = 256 for speed codes 00 and 11 and T = 128 for codes 01 and 10; A = 2 when `halve_sel_i[0]` is 1 and 1 otherwise; B is the same for `halve_sel_i[1]`; F = 1.5 when `frac_sel_i` is 1 and 1 otherwise.
- R3: With `frac_sel_i` = 1 the prescaler yields two ticks for every three master-clock cycles, so a frame lasts 1.5 times as many master-clock cycles as it does with `frac_sel_i` = 0.
- R4: Each bit of `halve_sel_i` on its own doubles the number of master-clock cycles per frame, and a prescaled tick is never followed by another tick in the next cycle while either bit is set.
- R5: Speed code 00 (single) gives 4 prescaled ticks per SCLK period and 256 per frame. Codes 01 (double) and 10 (quad) give 2 ticks per SCLK period and 128 per frame. Code 11 behaves exactly as 00.
- R6: Each LRCK period holds exactly 64 SCLK rising edges and 64 SCLK falling edges. LRCK is high for H master-clock cycles and low for H cycles.
- R7: `lrck_o` changes only in a cycle whose `sclk_rise_o`/`sclk_fall_o` report shows a falling SCLK edge at the same clock edge (`sclk_fall_o` = 1).
- R8: `sclk_rise_o` is 1 exactly in the first cycle in which `sclk_o` reads 1 after reading 0. `sclk_fall_o` is 1 exactly in the first cycle in which it reads 0 after reading 1. `lrck_edge_o` is 1 exactly in the first cycle after `lrck_o` changes.
- R9: Select inputs that change mid-frame take effect only at the next LRCK falling edge. The current frame completes with the old settings, and the following low half-frame lasts H cycles of the new setting, because all counters restart at that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; selects are loaded while high |
| frac_sel_i | input | 1 | 1: first prescale stage divides by 1.5; 0: by 1 |
| halve_sel_i | input | 2 | Per-bit halving enable of the two following prescale stages |
| speed_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 treated as single |
| sclk_o | output | 1 | Registered bit-clock level |
| lrck_o | output | 1 | Registered frame-clock level, low in the first half of each frame |
| sclk_rise_o | output | 1 | One-cycle pulse in the first cycle of SCLK high |
| sclk_fall_o | output | 1 | One-cycle pulse in the first cycle of SCLK low |
| lrck_edge_o | output | 1 | One-cycle pulse in the first cycle after any LRCK change |

## Verification
The embedded properties take the select inputs as quasi-static. They assume the selects hold steady across the last reset cycle and the first cycle after it. Once out of reset, the properties can still depend on the latched configuration changing only at a frame boundary. The stimulus therefore changes the selects only at points away from clock edges, either while reset is held or at arbitrary points inside a running frame, where the block must hold them off until the next LRCK fall. The bench resets into every combination of the three select fields and the four speed codes, including the unused code. It then switches between constrained random settings mid-frame, both while LRCK is high and while it is low.

// File: rtl/amcd_pkg.sv
package amcd_pkg;

    localparam int HALVE_STAGES = 2;
    localparam int FRAC_LEN     = 3;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic                    frac;
        logic [HALVE_STAGES-1:0] halve;
        speed_e                  speed;
    } cfg_t;

    // 1 when each SCLK half period spans two prescaled ticks
    function automatic logic slow_speed(speed_e s);
        return !(s == SPD_DOUBLE || s == SPD_QUAD);
    endfunction

endpackage

// File: rtl/amcd_prescale.sv
module amcd_prescale
    import amcd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    frac_i,
    input  logic [HALVE_STAGES-1:0] halve_i,
    output logic                    tick_o
);
    localparam int FCW = $clog2(FRAC_LEN);

    typedef struct packed {
        logic [FCW-1:0]          fcnt;
        logic [HALVE_STAGES-1:0] tog;
    } pre_st_t;

    pre_st_t s_q, s_nx, s_d;
    logic    run;

    // enable chain: fractional stage, then the halving stages in turn
    always_comb begin
        s_nx = s_q;
        if (frac_i) begin
            run = (s_q.fcnt != '0);
            s_nx.fcnt = (s_q.fcnt == FCW'(FRAC_LEN - 1)) ? '0 : s_q.fcnt + 1'b1;
        end else begin
            run = 1'b1;
            s_nx.fcnt = '0;
        end
        for (int i = 0; i < HALVE_STAGES; i++) begin
            if (halve_i[i]) begin
                if (run) begin
                    s_nx.tog[i] = ~s_q.tog[i];
                end
                run = run && s_q.tog[i];
            end
        end
        tick_o = run;
    end

    always_comb begin
        s_d = restart ? '0 : s_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3
    fc_range_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.fcnt < FCW'(FRAC_LEN));

    // R4
    halve_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (|halve_i && tick_o && !restart) |=> !tick_o);

endmodule

// File: rtl/amcd_sclk.sv
module amcd_sclk (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick_i,
    input  logic slow_i,
    output logic fall_now_o,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic ph;
        logic sclk;
        logic rise;
        logic fall;
    } bclk_st_t;

    bclk_st_t s_q, s_nx, s_d;
    logic     toggle;

    always_comb begin
        s_nx   = s_q;
        toggle = tick_i && (!slow_i || s_q.ph);
        if (tick_i && slow_i) begin
            s_nx.ph = ~s_q.ph;
        end
        s_nx.sclk  = s_q.sclk ^ toggle;
        s_nx.rise  = toggle && !s_q.sclk;
        s_nx.fall  = toggle && s_q.sclk;
        fall_now_o = s_nx.fall;
    end

    always_comb begin
        s_d = s_nx;
        if (restart) begin
            s_d.ph   = 1'b0;
            s_d.sclk = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.sclk;
    assign rise_o = s_q.rise;
    assign fall_o = s_q.fall;

    // R8
    sclk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.sclk) |-> s_q.rise);

    // R8
    sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(s_q.rise && s_q.fall));

endmodule

// File: rtl/amcd_frame.sv
module amcd_frame #(
    parameter int HALF_BITS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_now_i,
    output logic frame_end_o,
    output logic lrck_o,
    output logic edge_o
);
    localparam int BW = $clog2(HALF_BITS);

    typedef struct packed {
        logic [BW-1:0] bcnt;
        logic          lrck;
        logic          edge_p;
    } frm_st_t;

    frm_st_t s_q, s_d;
    logic    last;

    always_comb begin
        s_d        = s_q;
        last       = (s_q.bcnt == BW'(HALF_BITS - 1));
        s_d.edge_p = 1'b0;
        if (fall_now_i) begin
            if (last) begin
                s_d.bcnt   = '0;
                s_d.lrck   = ~s_q.lrck;
                s_d.edge_p = 1'b1;
            end else begin
                s_d.bcnt = s_q.bcnt + 1'b1;
            end
        end
        frame_end_o = fall_now_i && last && s_q.lrck;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lrck_o = s_q.lrck;
    assign edge_o = s_q.edge_p;

    // R7
    lrck_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.lrck != $past(s_q.lrck)) |-> $past(fall_now_i));

    // R6
    frame_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> (!s_q.lrck && s_q.bcnt == '0));

endmodule

// File: rtl/audio_mclk_div.sv
module audio_mclk_div
    import amcd_pkg::*;
#(
    parameter int SCLK_PER_FRAME = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frac_sel_i,
    input  logic [HALVE_STAGES-1:0] halve_sel_i,
    input  logic [1:0]              speed_i,
    output logic                    sclk_o,
    output logic                    lrck_o,
    output logic                    sclk_rise_o,
    output logic                    sclk_fall_o,
    output logic                    lrck_edge_o
);
    localparam int HALF_BITS = SCLK_PER_FRAME / 2;

    cfg_t cfg_in, cfg_q, cfg_d;
    logic tick, fall_now, frame_end;

    always_comb begin
        cfg_in.frac  = frac_sel_i;
        cfg_in.halve = halve_sel_i;
        cfg_in.speed = speed_e'(speed_i);
        cfg_d        = (rst || frame_end) ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    amcd_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (frame_end),
        .frac_i  (cfg_q.frac),
        .halve_i (cfg_q.halve),
        .tick_o  (tick)
    );

    amcd_sclk u_bclk (
        .clk        (clk),
        .rst        (rst),
        .restart    (frame_end),
        .tick_i     (tick),
        .slow_i     (slow_speed(cfg_q.speed)),
        .fall_now_o (fall_now),
        .sclk_o     (sclk_o),
        .rise_o     (sclk_rise_o),
        .fall_o     (sclk_fall_o)
    );

    amcd_frame #(.HALF_BITS(HALF_BITS)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .fall_now_i  (fall_now),
        .frame_end_o (frame_end),
        .lrck_o      (lrck_o),
        .edge_o      (lrck_edge_o)
    );

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_end)) |-> $stable(cfg_q));

endmodule

// File: tb/audio_mclk_div_tb_top.sv
module audio_mclk_div_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SPF        = 64;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frac = 1'b0;
    logic [1:0] halve = 2'b00;
    logic [1:0] speed = 2'b00;
    logic sclk_o, lrck_o, sclk_rise_o, sclk_fall_o, lrck_edge_o;

    int  checks = 0, errors = 0;
    bit  done = 0;
    int  rise_cnt = 0, fall_cnt = 0, pulse_bad = 0, lrck_bad = 0;
    logic prev_s = 1'b0, prev_l = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_mclk_div #(.SCLK_PER_FRAME(SPF)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .frac_sel_i  (frac),
        .halve_sel_i (halve),
        .speed_i     (speed),
        .sclk_o      (sclk_o),
        .lrck_o      (lrck_o),
        .sclk_rise_o (sclk_rise_o),
        .sclk_fall_o (sclk_fall_o),
        .lrck_edge_o (lrck_edge_o)
    );

    function automatic int exp_half(bit f, logic [1:0] h, logic [1:0] sp);
        int c;
        c = (sp == 2'b01 || sp == 2'b10) ? 64 : 128;
        c = c * (h[0] ? 2 : 1) * (h[1] ? 2 : 1);
        return f ? (c * 3) / 2 : c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (!rst) begin
            if (sclk_rise_o !== (sclk_o && !prev_s)) pulse_bad++;
            if (sclk_fall_o !== (!sclk_o && prev_s)) pulse_bad++;
            if (lrck_edge_o !== (lrck_o != prev_l)) pulse_bad++;
            if ((lrck_o != prev_l) && !sclk_fall_o) lrck_bad++;
            rise_cnt += int'(sclk_rise_o);
            fall_cnt += int'(sclk_fall_o);
        end
        prev_s = sclk_o;
        prev_l = lrck_o;
    endtask

    task automatic wait_lrck(input logic target, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (lrck_o !== target && n < 5000);
    endtask

    task automatic apply_cfg(bit f, logic [1:0] h, logic [1:0] sp);
        frac  = f;
        halve = h;
        speed = sp;
    endtask

    task automatic start_frame_counts();
        rise_cnt = 0;
        fall_cnt = 0;
        pulse_bad = 0;
        lrck_bad = 0;
    endtask

    task automatic check_frame(int h_exp, string req);
        int n;
        start_frame_counts();
        wait_lrck(1'b0, n);
        check(n == h_exp, "R6", "high half cycles", n, h_exp);
        wait_lrck(1'b1, n);
        check(n == h_exp, req, "low half cycles", n, h_exp);
        check(rise_cnt == SPF, "R6", "sclk rises per frame", rise_cnt, SPF);
        check(fall_cnt == SPF, "R6", "sclk falls per frame", fall_cnt, SPF);
        check(pulse_bad == 0, "R8", "pulse mismatches", pulse_bad, 0);
        check(lrck_bad == 0, "R7", "lrck moves off sclk fall", lrck_bad, 0);
    endtask

    initial begin
        int n, h_exp, h_old, h_new;
        bit f_r;
        logic [1:0] h_r, s_r;
        string req;
        void'($urandom(32'd20240611));

        // directed sweep: every select combination, reset into each one
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < 4; h++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    rst = 1'b1;
                    apply_cfg(f[0], h[1:0], sp[1:0]);
                    repeat (3) step();
                    // R1 outputs quiet while reset is held
                    check({sclk_o, lrck_o, sclk_rise_o, sclk_fall_o, lrck_edge_o} == 5'b0,
                          "R1", "outputs in reset",
                          int'({sclk_o, lrck_o, sclk_rise_o, sclk_fall_o, lrck_edge_o}), 0);
                    rst = 1'b0;
                    h_exp = exp_half(f[0], h[1:0], sp[1:0]);
                    start_frame_counts();
                    wait_lrck(1'b1, n);
                    check(n == h_exp, "R2", "first lrck rise", n, h_exp);
                    check(rise_cnt == SPF / 2, "R5", "sclk rises before first lrck", rise_cnt, SPF / 2);
                    req = f ? "R3" : ((h != 0) ? "R4" : "R5");
                    check_frame(h_exp, req);
                end
            end
        end

        // constrained random mid-frame changes while lrck is high (just after a rise)
        h_old = exp_half(frac, halve, speed);
        for (int k = 0; k < 8; k++) begin
            f_r = 1'($urandom_range(0, 1));
            h_r = 2'($urandom_range(0, 3));
            s_r = 2'($urandom_range(0, 3));
            apply_cfg(f_r, h_r, s_r);
            h_new = exp_half(f_r, h_r, s_r);
            wait_lrck(1'b0, n);
            check(n == h_old, "R9", "old frame completes", n, h_old);
            wait_lrck(1'b1, n);
            check(n == h_new, "R9", "new low half after boundary", n, h_new);
            check_frame(h_new, "R9");
            h_old = h_new;
        end

        // directed: change during the low half; two more old halves must follow
        wait_lrck(1'b0, n);
        apply_cfg(1'b1, 2'b11, 2'b00);
        h_new = exp_half(1'b1, 2'b11, 2'b00);
        if (h_new == h_old) begin
            apply_cfg(1'b0, 2'b00, 2'b10);
            h_new = exp_half(1'b0, 2'b00, 2'b10);
        end
        wait_lrck(1'b1, n);
        check(n == h_old, "R9", "low half keeps old setting", n, h_old);
        wait_lrck(1'b0, n);
        check(n == h_old, "R9", "high half keeps old setting", n, h_old);
        wait_lrck(1'b1, n);
        check(n == h_new, "R9", "setting applied at boundary", n, h_new);

        // directed: reserved code behaves as single speed
        rst = 1'b1;
        apply_cfg(1'b0, 2'b01, 2'b11);
        repeat (2) step();
        rst = 1'b0;
        wait_lrck(1'b1, n);
        check(n == exp_half(1'b0, 2'b01, 2'b00), "R5", "code 11 as single", n,
              exp_half(1'b0, 2'b01, 2'b00));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2: actual %0d expected %0d", WD_CYCLES, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule